// File: doc/BRIEF.md
# Bus Ownership Hand-Off Arbiter

This block sits on the side of the master that currently owns a shared parallel bus and handles a request from one outside master to take the bus over. A request coming in is passed through a synchronizer. Once no transfer is under way and no locked read-modify-write sequence is holding the bus, the owner turns its address, data and control drivers off and raises the grant. The grant stays up until the new master acknowledges. When the acknowledge arrives the grant is taken down, and the bus is left to the other master until both acknowledge and request have gone away. Only then, one clock later, does the owner turn its drivers back on.

The request and acknowledge inputs pass through a chain of flops. The busy and lock inputs come from the owner's own clock domain and are used as they are. The grant output is registered on the falling clock edge, half a clock after the decision is taken on the rising edge. A width timer keeps each high and each low period of the grant at least a set number of clocks long. If the request is withdrawn before any acknowledge arrives, the grant is pulled back and the owner reclaims the bus. If the request is still held after the acknowledge has dropped, the grant is issued again.

Top module: `bus_handoff_arb`

## Requirements
- R1: While reset is asserted and right after it is released, grant is low and the driver enable is high.
- R2: With busy and lock low, a request raised before rising edge n makes the driver enable fall at rising edge n+2 (two synchronizer stages plus one state register, so 3 calls in the bench). Grant rises on the falling edge that follows.
- R3: No grant is issued while the lock input is high. Once lock is sampled low at a rising edge with a synchronized request present, the grant starts at that edge.
- R4: No grant is issued while the busy input is high, under the same timing rule as R3.
- R5: A synchronized acknowledge removes the grant at the next rising edge, once the high time of R7 is met. The driver enable stays low while the other master holds the bus.
- R6: The driver enable returns high exactly one clock after the rising edge at which the synchronized acknowledge and the synchronized request are both seen low.
- R7: Every high period of grant lasts at least GNT_MIN_CLKS clocks (default 3).
- R8: Every low period of grant between two grants lasts at least GNT_GAP_CLKS clocks (default 3).
- R9: If the request is still held after the acknowledge drops, a new grant is issued without the owner driving the bus in between.
- R10: If the request is withdrawn before any acknowledge, the grant is removed once R7 allows, and the driver enable rises one clock later.
- R11: Grant changes only on falling clock edges.
- R12: Grant and the driver enable are never high together. The driver enable is low in every state except owner-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Request from the outside master, asynchronous |
| bus_ack_i | input | 1 | Acknowledge that the outside master has taken the bus, asynchronous |
| cyc_busy_i | input | 1 | The owner has a bus cycle in progress |
| rmw_lock_i | input | 1 | The owner is inside an indivisible read-modify-write sequence |
| bus_grant_o | output | 1 | Bus grant, updated on the falling edge |
| drv_en_o | output | 1 | Enable for the owner's address, data and control drivers |

## Verification
The hardest case to reach from the ports is a re-grant out of the held state. The acknowledge has to rise and fall while the request stays up, so the minimum-low timer, not the synchronizer, decides when the grant returns. The stimulus holds the request for the whole run and sweeps the acknowledge pulse length from one to five clocks. Short pulses land on the timer bound and long pulses land on the acknowledge release. Lock and busy release times are crossed with each other against the fixed synchronizer latency, and request withdrawal is swept across the minimum-high window.

// File: rtl/bao_pkg.sv
package bao_pkg;
  typedef enum logic [1:0] {
    ST_OWN  = 2'd0,
    ST_GNT  = 2'd1,
    ST_HELD = 2'd2,
    ST_BACK = 2'd3
  } arb_state_e;
endpackage

// File: rtl/bao_sync.sv
module bao_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bao_timer.sv
module bao_timer #(
  parameter int HI_CLKS = 3,
  parameter int LO_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic hi_ok_o,
  output logic lo_ok_o
);
  localparam int MAXV = (HI_CLKS > LO_CLKS) ? HI_CLKS : LO_CLKS;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAXV);
  localparam logic [CW-1:0] HI_T = CW'(HI_CLKS - 1);
  localparam logic [CW-1:0] LO_T = CW'(LO_CLKS - 1);

  logic [CW-1:0] cnt_q;

  // counts clocks spent at the current grant level; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CMAX;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hi_ok_o = cnt_q >= HI_T;
  assign lo_ok_o = cnt_q >= LO_T;
endmodule

// File: rtl/bao_fsm.sv
module bao_fsm
  import bao_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic ack_s_i,
  input  logic busy_i,
  input  logic lock_i,
  input  logic hi_ok_i,
  input  logic lo_ok_i,
  output logic gnt_st_o,
  output logic own_st_o,
  output logic restart_o
);
  arb_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_OWN:  if (req_s_i && !busy_i && !lock_i && lo_ok_i) st_n = ST_GNT;
      ST_GNT:  if (hi_ok_i) begin
                 if (ack_s_i)       st_n = ST_HELD;
                 else if (!req_s_i) st_n = ST_BACK;
               end
      ST_HELD: if (!ack_s_i) begin
                 if (!req_s_i)     st_n = ST_BACK;
                 else if (lo_ok_i) st_n = ST_GNT;
               end
      ST_BACK: st_n = ST_OWN;
      default: st_n = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OWN;
    else         st_q <= st_n;
  end

  assign gnt_st_o  = (st_q == ST_GNT);
  assign own_st_o  = (st_q == ST_OWN);
  assign restart_o = (st_n == ST_GNT) != (st_q == ST_GNT);

  p_lock_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OWN && lock_i) |=> (st_q == ST_OWN));

  p_busy_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OWN && busy_i) |=> (st_q == ST_OWN));

  p_held_while_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HELD && ack_s_i) |=> (st_q == ST_HELD));
endmodule

// File: rtl/bus_handoff_arb.sv
module bus_handoff_arb #(
  parameter int SYNC_STAGES  = 2,
  parameter int GNT_MIN_CLKS = 3,
  parameter int GNT_GAP_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  input  logic bus_ack_i,
  input  logic cyc_busy_i,
  input  logic rmw_lock_i,
  output logic bus_grant_o,
  output logic drv_en_o
);
  logic req_s, ack_s, hi_ok, lo_ok, gnt_st, own_st, restart;

  bao_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_ack_i, bus_req_i}),
    .q_o   ({ack_s, req_s})
  );

  bao_timer #(.HI_CLKS(GNT_MIN_CLKS), .LO_CLKS(GNT_GAP_CLKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .hi_ok_o  (hi_ok),
    .lo_ok_o  (lo_ok)
  );

  bao_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_s_i  (req_s),
    .ack_s_i  (ack_s),
    .busy_i   (cyc_busy_i),
    .lock_i   (rmw_lock_i),
    .hi_ok_i  (hi_ok),
    .lo_ok_i  (lo_ok),
    .gnt_st_o (gnt_st),
    .own_st_o (own_st),
    .restart_o(restart)
  );

  // grant launched half a clock after the decision edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_grant_o <= 1'b0;
    else         bus_grant_o <= gnt_st;
  end

  assign drv_en_o = own_st;

  // run-length monitors for the width assertions
  localparam int RW = $clog2(GNT_MIN_CLKS + GNT_GAP_CLKS + 1);
  localparam logic [RW-1:0] HI_SAT = RW'(GNT_MIN_CLKS);
  localparam logic [RW-1:0] LO_SAT = RW'(GNT_GAP_CLKS);
  logic [RW-1:0] hi_run, lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= LO_SAT;
    end else if (gnt_st) begin
      lo_run <= '0;
      if (hi_run != HI_SAT) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != LO_SAT) lo_run <= lo_run + 1'b1;
    end
  end

  p_min_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gnt_st) |-> (hi_run >= HI_SAT));

  p_min_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_st) |-> (lo_run >= LO_SAT));

  p_regain_after_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(!ack_s && !req_s, 2));

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> !drv_en_o);
endmodule

// File: tb/bus_handoff_arb_test.sv
`timescale 1ns/1ps
module bus_handoff_arb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b0, busy = 1'b0, lock = 1'b0;
  logic grant, drv;
  logic g_pre, g_now, d_now, prev_g;
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  bus_handoff_arb uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_req_i  (req),
    .bus_ack_i  (ack),
    .cyc_busy_i (busy),
    .rmw_lock_i (lock),
    .bus_grant_o(grant),
    .drv_en_o   (drv)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input int c);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s call %0d: got %0b expected %0b", tag, c, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 0; ack = 0; busy = 0; lock = 0;
    repeat (2) @(posedge clk);
    #2;
    chk(grant, 1'b0, "R1", -1);
    chk(drv, 1'b1, "R1", -1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(grant, 1'b0, "R1", -1);
    chk(drv, 1'b1, "R1", -1);
    prev_g = 1'b0;
  endtask

  // one clock: drive after the rising edge, sample after the falling edge
  task automatic step(input int c, input int req_end, input int ack_st, input int ack_end,
                      input int lock_end, input int busy_end);
    @(posedge clk);
    #1;
    req  = (c < req_end);
    ack  = (c >= ack_st) && (c < ack_end);
    lock = (c < lock_end);
    busy = (c < busy_end);
    g_pre = grant;
    #5;
    g_now = grant;
    d_now = drv;
    chk(g_pre, prev_g, "R11", c);
    chk(!(g_now && d_now), 1'b1, "R12", c);
    prev_g = g_now;
  endtask

  initial begin
    // lock / busy release sweep with a full acknowledge hand-off
    for (int l = 0; l < 6; l++) begin
      for (int b = 0; b < 6; b++) begin
        int g;
        string tg;
        g = 3;
        if (l + 1 > g) g = l + 1;
        if (b + 1 > g) g = b + 1;
        tg = (l == 0 && b == 0) ? "R2" : ((l >= b) ? "R3" : "R4");
        do_reset();
        for (int c = 0; c <= g + 10; c++) begin
          step(c, g, g, g + 4, l, b);
          if (c < g) chk(g_now, 1'b0, tg, c);
          else if (c < g + 3) chk(g_now, 1'b1, "R7", c);
          else chk(g_now, 1'b0, "R5", c);
          if (c < g) chk(d_now, 1'b1, tg, c);
          else if (c < g + 8) chk(d_now, 1'b0, "R6", c);
          else chk(d_now, 1'b1, "R6", c);
        end
      end
    end

    // request withdrawn before any acknowledge
    for (int k = 1; k <= 6; k++) begin
      int e;
      e = (k + 3 > 6) ? k + 3 : 6;
      do_reset();
      for (int c = 0; c <= e + 4; c++) begin
        step(c, k, 999, 999, 0, 0);
        chk(g_now, (c >= 3 && c < e), "R10", c);
        chk(d_now, !(c >= 3 && c < e + 1), "R10", c);
      end
    end

    // acknowledge pulse with the request still held: re-grant
    for (int w = 1; w <= 5; w++) begin
      int r;
      r = (6 + w > 9) ? 6 + w : 9;
      do_reset();
      for (int c = 0; c <= r + 1; c++) begin
        step(c, 999, 3, 3 + w, 0, 0);
        if (c >= 6 && c < 9) chk(g_now, 1'b0, "R8", c);
        else chk(g_now, (c >= 3 && c < 6) || (c >= r), "R9", c);
        chk(d_now, (c < 3), "R9", c);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule